// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Alarm

This block keeps wall-clock time and date as packed BCD fields: seconds, minutes, hours (24-hour), day of month, month, two-digit year, plus a binary weekday. A single-cycle `tick` input, pulsed once per second by a prescaler outside the block, advances the count while the run bit is set. Software reaches every field through a small synchronous register bus. Writes take effect on the clock edge. Reads return data one clock after `rd_en`.

Software gets a coherent multi-byte view of the time by writing a snapshot strobe. This copies all six date and time fields into shadow latches in one clock, and time reads are then served from those latches. Clearing the run bit freezes the count so the time can be rewritten safely. The block also latches periodic second, minute, hour and day events. An alarm compares the advancing time against six programmed fields, and a single interrupt output combines the alarm with one selectable periodic event.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the time is 00:00:00, day 01, month 01, year 00, weekday 0, the control register is 0x00, the status register reads 0x80 (only the power-up flag, bit 7), the interrupt-enable register is 0 and `irq` is low.
- R2: Address map: 0x00 seconds, 0x01 minutes, 0x02 hours, 0x03 day, 0x04 month, 0x05 year, 0x06 weekday, 0x07–0x0C alarm seconds through alarm year (same field order), 0x0D control, 0x0E status, 0x0F interrupt enable (bits 3:0), 0x10/0x11 two compensation bytes that are stored and read back without effect. Any other address reads 0x00. `rdata` updates one clock after a cycle with `rd_en` high.
- R3: Control bit 0 is the run bit. A `tick` advances the time only while it is 1. With it at 0, ticks leave every time field unchanged.
- R4: Writing the control register with bit 6 set copies seconds through year into shadow latches in that same clock. Reads of 0x00–0x05 always return the shadow latches, so later ticks are not visible until the next snapshot. Weekday reads return the live value. Bit 6 is not stored and reads back 0.
- R5: Seconds and minutes wrap 59→00 and hours wrap 23→00. Control bits 1 and 3 are stored and read back but do not change the counting, which stays 24-hour.
- R6: On the hour wrap, the day advances and the weekday advances 0..6, wrapping to 0. A day equal to the month's length returns to 01 and advances the month. Lengths are 31, or 30 for months 4, 6, 9 and 11, or 28 for month 2, or 29 for month 2 when the year is a multiple of 4. Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R7: Status bits 2, 3, 4 and 5 are the second, minute, hour and day event flags. Each counting tick loads them with the rollovers that tick caused: the second flag is always set, the minute flag when seconds wrap, the hour flag when minutes also wrap, and the day flag when hours also wrap. They then hold until the next tick, and a tick while stopped clears them.
- R8: When a counting tick produces a time whose six fields (seconds through year) all equal the alarm registers, status bit 6 is set.
- R9: Status bits 6 (alarm) and 7 (power-up) clear when written with 1. Writing 0 to them has no effect. A new alarm match in the same clock wins over the clear.
- R10: `irq` goes high one clock after status changes to satisfy (alarm flag AND enable bit 3) OR (selected event flag AND enable bit 2). Enable bits 1:0 select the event: 00 second, 01 minute, 10 hour, 11 day.
- R11: A bus write to a time field in the same clock as a counting tick stores the written value in that field, while the other fields still advance.
- R12: Status bit 1 reads as the current run bit. Status bit 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock pulse per second |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
Time fields, event flags, the alarm flag, snapshot latches and register writes all change on the clock edge that samples `tick` or `wr_en`. `rdata` follows one edge after `rd_en`, and `irq` follows one edge after the status flags that feed it. The bench drives every stimulus for exactly one clock between falling edges and samples `rdata` at the falling edge after the read strobe. It checks `irq` only after one more falling edge past the tick or write that changed the status. Time is always compared through a fresh snapshot against a bench calendar model, except in the check that shows the latches holding a stale value.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned NFIELD = 7;   // sec, min, hour, day, month, year, weekday
  localparam int unsigned NALM   = 6;   // alarm covers sec..year
  localparam int unsigned NCMP   = 2;

  localparam int unsigned F_SEC  = 0;
  localparam int unsigned F_MIN  = 1;
  localparam int unsigned F_HOUR = 2;
  localparam int unsigned F_DAY  = 3;
  localparam int unsigned F_MON  = 4;
  localparam int unsigned F_YEAR = 5;
  localparam int unsigned F_WDAY = 6;

  localparam int unsigned A_ALM0 = 7;
  localparam int unsigned A_CTRL = 13;
  localparam int unsigned A_STAT = 14;
  localparam int unsigned A_IEN  = 15;
  localparam int unsigned A_CMP0 = 16;

  localparam int unsigned B_RUN  = 0;
  localparam int unsigned B_SNAP = 6;
  localparam int unsigned B_ALM  = 6;
  localparam int unsigned B_PWR  = 7;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    logic [1:0] mod4;
    mod4 = {yr[4], 1'b0} + yr[1:0];   // 10*hi + lo mod 4 = 2*hi + lo mod 4
    case (mon)
      8'h02:                      return (mod4 == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    step,
  input  logic [NFIELD-1:0]       wsel,
  input  logic [7:0]              wdata,
  output logic [NFIELD-1:0][7:0]  fld_q,
  output logic [NFIELD-1:0][7:0]  fld_nx,
  output logic [3:0]              evt
);
  logic wrap_sec, wrap_min, wrap_hr, wrap_day, wrap_mon;
  logic roll_min, roll_hr, roll_day, roll_mon, roll_yr;

  always_comb begin
    wrap_sec = fld_q[F_SEC]  >= 8'h59;
    wrap_min = fld_q[F_MIN]  >= 8'h59;
    wrap_hr  = fld_q[F_HOUR] >= 8'h23;
    wrap_day = fld_q[F_DAY]  >= month_len(fld_q[F_MON], fld_q[F_YEAR]);
    wrap_mon = fld_q[F_MON]  >= 8'h12;
    roll_min = wrap_sec;
    roll_hr  = roll_min && wrap_min;
    roll_day = roll_hr  && wrap_hr;
    roll_mon = roll_day && wrap_day;
    roll_yr  = roll_mon && wrap_mon;

    fld_nx = fld_q;
    fld_nx[F_SEC] = wrap_sec ? 8'h00 : bcd_inc(fld_q[F_SEC]);
    if (roll_min) fld_nx[F_MIN]  = wrap_min ? 8'h00 : bcd_inc(fld_q[F_MIN]);
    if (roll_hr)  fld_nx[F_HOUR] = wrap_hr  ? 8'h00 : bcd_inc(fld_q[F_HOUR]);
    if (roll_day) begin
      fld_nx[F_DAY]  = wrap_day ? 8'h01 : bcd_inc(fld_q[F_DAY]);
      fld_nx[F_WDAY] = (fld_q[F_WDAY] >= 8'd6) ? 8'd0 : fld_q[F_WDAY] + 8'd1;
    end
    if (roll_mon) fld_nx[F_MON]  = wrap_mon ? 8'h01 : bcd_inc(fld_q[F_MON]);
    if (roll_yr)  fld_nx[F_YEAR] = (fld_q[F_YEAR] >= 8'h99) ? 8'h00 : bcd_inc(fld_q[F_YEAR]);

    evt = step ? {roll_day, roll_hr, roll_min, 1'b1} : 4'b0000;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NFIELD; i++) begin
      if (rst)          fld_q[i] <= (i == F_DAY || i == F_MON) ? 8'h01 : 8'h00;
      else if (wsel[i]) fld_q[i] <= wdata;
      else if (step)    fld_q[i] <= fld_nx[i];
    end
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_pkg::*;
(
  input  logic                  step,
  input  logic [NALM-1:0][7:0]  next_time,
  input  logic [NALM-1:0][7:0]  alarm,
  output logic                  hit
);
  logic [NALM-1:0] eq;

  for (genvar i = 0; i < NALM; i++) begin : g_cmp
    assign eq[i] = (next_time[i] == alarm[i]);
  end

  assign hit = step && (&eq);
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  output logic              irq
);
  logic [NFIELD-1:0][7:0] fld_q, fld_nx;
  logic [NALM-1:0][7:0]   shadow_q, alm_q;
  logic [NCMP-1:0][7:0]   cmp_q;
  logic [NFIELD-1:0]      wsel;
  logic [7:0]             ctrl_q;
  logic [3:0]             ien_q, evt_d, evt_q;
  logic                   alm_st_q, pwr_st_q, alm_hit, step, snap;
  logic                   wr_ctrl, wr_stat, wr_ien;
  logic [ADDR_W-1:0]      aoff;
  logic [7:0]             rd_mux, stat_word;

  assign step    = tick && ctrl_q[B_RUN];
  assign wr_ctrl = wr_en && (addr == ADDR_W'(A_CTRL));
  assign wr_stat = wr_en && (addr == ADDR_W'(A_STAT));
  assign wr_ien  = wr_en && (addr == ADDR_W'(A_IEN));
  assign snap    = wr_ctrl && wdata[B_SNAP];
  assign aoff    = addr - ADDR_W'(A_ALM0);

  always_comb begin
    for (int i = 0; i < NFIELD; i++) wsel[i] = wr_en && (addr == ADDR_W'(i));
  end

  rtc_time_chain u_chain (
    .clk   (clk),
    .rst   (rst),
    .step  (step),
    .wsel  (wsel),
    .wdata (wdata),
    .fld_q (fld_q),
    .fld_nx(fld_nx),
    .evt   (evt_d)
  );

  rtc_alarm_match u_match (
    .step     (step),
    .next_time(fld_nx[NALM-1:0]),
    .alarm    (alm_q),
    .hit      (alm_hit)
  );

  // configuration and shadow registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= 8'h00;
      ien_q    <= 4'h0;
      alm_q    <= '0;
      cmp_q    <= '0;
      shadow_q <= {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
    end else begin
      if (wr_ctrl) ctrl_q <= wdata & ~(8'h01 << B_SNAP);
      if (wr_ien)  ien_q  <= wdata[3:0];
      if (snap)    shadow_q <= fld_q[NALM-1:0];
      for (int i = 0; i < NALM; i++)
        if (wr_en && addr == ADDR_W'(A_ALM0 + i)) alm_q[i] <= wdata;
      for (int i = 0; i < NCMP; i++)
        if (wr_en && addr == ADDR_W'(A_CMP0 + i)) cmp_q[i] <= wdata;
    end
  end

  // status flags
  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q    <= 4'h0;
      alm_st_q <= 1'b0;
      pwr_st_q <= 1'b1;
    end else begin
      if (tick) evt_q <= evt_d;
      if (alm_hit)                   alm_st_q <= 1'b1;
      else if (wr_stat && wdata[B_ALM]) alm_st_q <= 1'b0;
      if (wr_stat && wdata[B_PWR])   pwr_st_q <= 1'b0;
    end
  end

  assign stat_word = {pwr_st_q, alm_st_q, evt_q, ctrl_q[B_RUN], 1'b0};

  always_comb begin
    rd_mux = 8'h00;
    if (addr <= ADDR_W'(F_YEAR))                         rd_mux = shadow_q[addr[2:0]];
    else if (addr == ADDR_W'(F_WDAY))                    rd_mux = fld_q[F_WDAY];
    else if (addr < ADDR_W'(A_ALM0 + NALM))              rd_mux = alm_q[aoff[2:0]];
    else if (addr == ADDR_W'(A_CTRL))                    rd_mux = ctrl_q;
    else if (addr == ADDR_W'(A_STAT))                    rd_mux = stat_word;
    else if (addr == ADDR_W'(A_IEN))                     rd_mux = {4'h0, ien_q};
    else if (addr == ADDR_W'(A_CMP0))                    rd_mux = cmp_q[0];
    else if (addr == ADDR_W'(A_CMP0 + 1))                rd_mux = cmp_q[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= 8'h00;
      irq   <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      irq <= (alm_st_q && ien_q[3]) || (evt_q[ien_q[1:0]] && ien_q[2]);
    end
  end
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic              irq,
  input logic              run,
  input logic [NFIELD*8-1:0] live,
  input logic [NALM*8-1:0] shadow,
  input logic              alm_st,
  input logic              pwr_st,
  input logic [3:0]        evt
);
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_en) |=> $stable(live)); // R3

  AST_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == ADDR_W'(A_CTRL) && wdata[B_SNAP]) |=> $stable(shadow)); // R4

  AST_EVT_FROM_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(|evt) |-> $past(tick)); // R7

  AST_ALM_W1C: assert property (@(posedge clk) disable iff (rst)
    $fell(alm_st) |-> $past(wr_en && addr == ADDR_W'(A_STAT) && wdata[B_ALM])); // R9

  AST_PWR_W1C: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_st) |-> $past(wr_en && addr == ADDR_W'(A_STAT) && wdata[B_PWR])); // R9

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(alm_st) || $past(|evt))); // R10
endmodule

bind bcd_rtc rtc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .tick  (tick),
  .wr_en (wr_en),
  .addr  (addr),
  .wdata (wdata),
  .irq   (irq),
  .run   (ctrl_q[0]),
  .live  (fld_q),
  .shadow(shadow_q),
  .alm_st(alm_st_q),
  .pwr_st(pwr_st_q),
  .evt   (evt_q)
);

// File: tb/bcd_rtc_bench.sv
`timescale 1ns/1ps
module bcd_rtc_bench;
  localparam int ADDR_W = 5;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic irq;

  int n_chk = 0, n_fail = 0;
  int sec, mn, hr, dy, mo, yr, wd;
  logic [7:0] ctrl_v = 8'h00;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  bcd_rtc #(.ADDR_W(ADDR_W)) u_bcd_rtc (
    .clk(clk), .rst(rst), .tick(tick), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .irq(irq)
  );

  function automatic logic [7:0] tob(input int x);
    return 8'(((x / 10) << 4) | (x % 10));
  endfunction

  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    addr = ADDR_W'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 13) ctrl_v = d & 8'hBF;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    addr = ADDR_W'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic m_tick();
    sec++;
    if (sec == 60) begin
      sec = 0; mn++;
      if (mn == 60) begin
        mn = 0; hr++;
        if (hr == 24) begin
          hr = 0; wd = (wd + 1) % 7; dy++;
          if (dy > dim(mo, yr)) begin
            dy = 1; mo++;
            if (mo == 13) begin mo = 1; yr = (yr + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      if (ctrl_v[0]) m_tick();
    end
  endtask

  task automatic set_time(input int s, input int m, input int h, input int d,
                          input int mth, input int y, input int w, input logic [7:0] c);
    wr(13, 8'h00);
    sec = s; mn = m; hr = h; dy = d; mo = mth; yr = y; wd = w;
    wr(0, tob(s)); wr(1, tob(m)); wr(2, tob(h));
    wr(3, tob(d)); wr(4, tob(mth)); wr(5, tob(y)); wr(6, 8'(w));
    wr(13, c);
  endtask

  task automatic check_time(input string req);
    wr(13, ctrl_v | 8'h40);
    rd(0, v); chk({req, " sec"},  v, tob(sec));
    rd(1, v); chk({req, " min"},  v, tob(mn));
    rd(2, v); chk({req, " hour"}, v, tob(hr));
    rd(3, v); chk({req, " day"},  v, tob(dy));
    rd(4, v); chk({req, " mon"},  v, tob(mo));
    rd(5, v); chk({req, " year"}, v, tob(yr));
    rd(6, v); chk({req, " wday"}, v, 8'(wd));
  endtask

  initial begin
    #(5.0 * 190000);
    n_fail++;
    $display("FAIL watchdog: got 0x00 expected 0x01 (run finished)");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd(14, v); chk("R1 status", v, 8'h80);
    rd(13, v); chk("R1 ctrl", v, 8'h00);
    rd(15, v); chk("R1 ien", v, 8'h00);
    sec = 0; mn = 0; hr = 0; dy = 1; mo = 1; yr = 0; wd = 0;
    check_time("R1 time");

    // R2 map extras
    rd(31, v); chk("R2 unused addr", v, 8'h00);
    wr(16, 8'hA5); wr(17, 8'h3C);
    rd(16, v); chk("R2 comp lo", v, 8'hA5);
    rd(17, v); chk("R2 comp hi", v, 8'h3C);
    wr(9, 8'h17); rd(9, v); chk("R2 alarm hour", v, 8'h17);

    // R3 stopped: ticks ignored; R7 stopped tick clears flags
    ticks(3);
    check_time("R3 stopped");
    rd(14, v); chk("R7 stopped no evt", v & 8'h3C, 8'h00);

    // R5 / R12 control bits and run status
    wr(13, 8'h4B);
    rd(13, v); chk("R4 snap bit reads 0 / R5 stored", v, 8'h0B);
    rd(14, v); chk("R12 run in status", v & 8'h03, 8'h02);
    set_time(59, 59, 23, 14, 3, 7, 2, 8'h0B);
    ticks(1);
    check_time("R5 24h wrap with mode bits");

    // R6 directed date corners
    set_time(59, 59, 23, 28, 2, 4, 6, 8'h01); ticks(1); check_time("R6 leap feb28");
    ticks(86400); check_time("R6 leap feb29");
    set_time(59, 59, 23, 28, 2, 5, 1, 8'h01); ticks(1); check_time("R6 feb28 nonleap");
    set_time(59, 59, 23, 30, 4, 10, 3, 8'h01); ticks(1); check_time("R6 apr30");
    set_time(59, 59, 23, 31, 1, 11, 4, 8'h01); ticks(1); check_time("R6 jan31");
    set_time(58, 59, 23, 31, 12, 99, 5, 8'h01); ticks(2); check_time("R6 year99 wrap");

    // R3/R5/R6 random runs against the model
    for (int it = 0; it < 20; it++) begin
      int ry, rm;
      ry = $urandom % 100; rm = 1 + $urandom % 12;
      set_time($urandom % 60, $urandom % 60, $urandom % 24, 1 + $urandom % dim(rm, ry),
               rm, ry, $urandom % 7, 8'h01);
      ticks($urandom % 300);
      check_time("R3 R5 R6 random");
    end

    // R4 snapshot holds
    set_time(10, 0, 0, 1, 1, 1, 0, 8'h01);
    check_time("R4 snap");
    ticks(5);
    rd(0, v); chk("R4 stale after ticks", v, 8'h10);
    check_time("R4 resnap");

    // R7 / R10 periodic events
    set_time(59, 0, 0, 1, 1, 1, 0, 8'h01);
    wr(15, 8'h01);
    ticks(1); @(negedge clk);
    chk("R10 timer disabled", {7'd0, irq}, 8'h00);
    wr(15, 8'h05);
    set_time(59, 0, 0, 1, 1, 1, 0, 8'h01);
    ticks(1); @(negedge clk);
    chk("R10 minute irq", {7'd0, irq}, 8'h01);
    rd(14, v); chk("R7 min evt", v & 8'h3C, 8'h0C);
    ticks(1); @(negedge clk);
    chk("R10 irq drops", {7'd0, irq}, 8'h00);
    rd(14, v); chk("R7 sec only", v & 8'h3C, 8'h04);
    wr(15, 8'h07);
    set_time(59, 59, 23, 31, 12, 99, 6, 8'h01);
    ticks(1); @(negedge clk);
    chk("R10 day irq", {7'd0, irq}, 8'h01);
    rd(14, v); chk("R7 all evt", v & 8'h3C, 8'h3C);
    check_time("R6 full wrap");

    // R8 / R9 / R10 alarm
    wr(15, 8'h08);
    set_time(10, 30, 12, 15, 6, 24, 3, 8'h01);
    wr(7, 8'h12); wr(8, 8'h30); wr(9, 8'h12); wr(10, 8'h15); wr(11, 8'h06); wr(12, 8'h24);
    ticks(1);
    rd(14, v); chk("R8 no early alarm", v & 8'h40, 8'h00);
    ticks(1); @(negedge clk);
    rd(14, v); chk("R8 alarm set", v & 8'h40, 8'h40);
    chk("R10 alarm irq", {7'd0, irq}, 8'h01);
    wr(14, 8'h3F);
    rd(14, v); chk("R9 write0 keeps", v & 8'hC0, 8'hC0);
    wr(14, 8'h40); @(negedge clk);
    rd(14, v); chk("R9 alarm cleared", v & 8'hC0, 8'h80);
    chk("R10 irq after clear", {7'd0, irq}, 8'h00);
    wr(14, 8'h80);
    rd(14, v); chk("R9 pwr cleared", v & 8'h80, 8'h00);

    // R11 simultaneous tick and write
    wr(15, 8'h00);
    set_time(59, 5, 10, 2, 2, 2, 1, 8'h01);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; addr = ADDR_W'(0); wdata = 8'h42;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    m_tick(); sec = 42;
    check_time("R11 write wins");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule